// File: doc/BRIEF.md
# Serial Peripheral Master with Buffer Policies

This block is the master side of a four-wire serial peripheral link. It holds one transmit holding word, one receive holding word and a shift register. It generates the serial clock, shifts data out and in at the same time, and drives a set of active-low select lines. Each word transfer moves one word in each direction. A configurable trigger decides what starts a word: either a write into the transmit holding word, or a read of the receive holding word. The trigger setting lets software run the link purely by reading when it only needs to receive.

Two policy bits set the behaviour at the buffer limits. If the transmit holding word is empty when a word starts, the block sends either all zeros or the most recently sent word again. If the receive holding word is still unread when a word completes, the new data either replaces it or is discarded. Clock idle level, sampling phase, word length (half or full data width) and a half-period divider are loaded through a configuration strobe. That strobe is honoured only while the link is idle.

Top module: `spim_master`

## Requirements
- R1: With `cfg_trig_read`=0 a word starts after each `tx_we` pulse, and `rx_re` starts nothing. With `cfg_trig_read`=1 a word starts after each `rx_re` pulse, and `tx_we` only fills the holding word.
- R2: At word start the shift register is loaded from the transmit selection and shifted out most significant bit first. At word end the word sampled on `miso` is presented on `rx_rdata`. With `cfg_wide`=0 the word is the low half of the data width and the upper half of `rx_rdata` reads 0.
- R3: With `cfg_send_zero`=1 and the transmit holding word empty, a started word sends all zeros.
- R4: With `cfg_send_zero`=0 and the transmit holding word empty, a started word repeats the previously sent word.
- R5: With `cfg_get_more`=1, a word completing while `rxf`=1 replaces `rx_rdata`.
- R6: With `cfg_get_more`=0, a word completing while `rxf`=1 is discarded, and `rx_rdata` keeps its value.
- R7: With `cfg_cpha`=0, each select line whose `cfg_sel` bit is set is driven low only while a word is in progress. All lines are high while the link is idle.
- R8: With `cfg_cpha`=1, `ss_n` is the inverse of the configured `cfg_sel` bits at all times, independent of transfers.
- R9: Each serial clock half period lasts max(`cfg_baud`,2) system clocks. A word therefore keeps `busy` high for 2×bits×max(`cfg_baud`,2) cycles, where bits is 8 or 16.
- R10: A `cfg_we` pulse is ignored while a word is in progress or queued.
- R11: While idle, `sck` rests at the `cfg_cpol` level. Data is sampled on the leading edge when `cfg_cpha`=0 and on the trailing edge when `cfg_cpha`=1.
- R12: `txf` goes high on a `tx_we` and falls when a word takes the holding word. `rxf` goes high when a word is stored and falls on `rx_re`. `busy` is high during a word.
- R13: After reset, `busy`, `txf` and `rxf` are 0, `rx_rdata` is 0, `sck` is 0 and every `ss_n` line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the configuration inputs below |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_wide | input | 1 | 0: half-width words; 1: full-width words |
| cfg_trig_read | input | 1 | 0: start on transmit write; 1: start on receive read |
| cfg_send_zero | input | 1 | Empty-transmit policy: 1 zeros, 0 repeat |
| cfg_get_more | input | 1 | Full-receive policy: 1 overwrite, 0 discard |
| cfg_baud | input | 16 | Half-period in system clocks (values below 2 act as 2) |
| cfg_sel | input | SEL_W | Select line enables |
| tx_we | input | 1 | Write strobe for the transmit holding word |
| tx_wdata | input | DATA_W | Transmit data |
| rx_re | input | 1 | Read strobe for the receive holding word |
| rx_rdata | output | DATA_W | Receive holding word |
| txf | output | 1 | Transmit holding word full |
| rxf | output | 1 | Receive holding word full |
| busy | output | 1 | Word in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SEL_W | Active-low select lines |

## Verification
The bench builds the block with its default parameters: a 16-bit data width and four select lines. Words of 8 and 16 bits are therefore both in reach, and the select mapping uses patterns that mix set and clear bits. Divider values 0 through 4 keep each word under 130 cycles. They also cover the clamp at 2 and every pairing of clock level with sampling phase. A loopback from `mosi` to `miso` plus an edge monitor on `sck` make the received word and the wire bit order both observable.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BAUD_W = 16;

    typedef enum logic {
        TRIG_ON_WRITE = 1'b0,
        TRIG_ON_READ  = 1'b1
    } trig_e;

    typedef struct packed {
        logic              cpol;
        logic              cpha;
        logic              wide;
        trig_e             trig;
        logic              send_zero;
        logic              get_more;
        logic [BAUD_W-1:0] baud;
    } cfg_t;

    function automatic logic [BAUD_W-1:0] eff_half(input logic [BAUD_W-1:0] b);
        return (b < BAUD_W'(2)) ? BAUD_W'(2) : b;
    endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int BAUD_W = 16,
    parameter int ECW    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic              cpol,
    input  logic [BAUD_W-1:0] half,
    input  logic [ECW-1:0]    last_idx,
    output logic              sck_r,
    output logic              lead,
    output logic              trail,
    output logic              last
);
    logic [BAUD_W-1:0] div;
    logic [ECW-1:0]    ecnt;
    logic              edge_now;

    assign edge_now = run && (div == half - BAUD_W'(1));
    assign lead     = edge_now && !ecnt[0];
    assign trail    = edge_now && ecnt[0];
    assign last     = edge_now && (ecnt == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            div   <= '0;
            ecnt  <= '0;
            sck_r <= 1'b0;
        end else if (start) begin
            div   <= '0;
            ecnt  <= '0;
            sck_r <= cpol;
        end else if (edge_now) begin
            div   <= '0;
            ecnt  <= ecnt + ECW'(1);
            sck_r <= ~sck_r;
        end else if (run) begin
            div   <= div + BAUD_W'(1);
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] load_word,
    input  logic              cpha,
    input  logic              wide,
    input  logic              lead,
    input  logic              trail,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    localparam int SHORT = DATA_W / 2;

    logic [DATA_W-1:0] txsh, rxsh, aligned, rx_full;
    logic              shift_ev, samp_ev, mo;

    assign shift_ev = cpha ? lead  : trail;
    assign samp_ev  = cpha ? trail : lead;
    assign aligned  = wide ? load_word : {load_word[SHORT-1:0], {SHORT{1'b0}}};
    assign rx_full  = samp_ev ? {rxsh[DATA_W-2:0], miso} : rxsh;
    assign rx_word  = wide ? rx_full : {{SHORT{1'b0}}, rx_full[SHORT-1:0]};
    assign mosi     = mo;

    always_ff @(posedge clk) begin
        if (rst) begin
            txsh <= '0;
            rxsh <= '0;
            mo   <= 1'b0;
        end else if (start) begin
            rxsh <= '0;
            if (cpha) begin
                txsh <= aligned;
            end else begin
                mo   <= aligned[DATA_W-1];
                txsh <= {aligned[DATA_W-2:0], 1'b0};
            end
        end else begin
            if (shift_ev) begin
                mo   <= txsh[DATA_W-1];
                txsh <= {txsh[DATA_W-2:0], 1'b0};
            end
            if (samp_ev) begin
                rxsh <= {rxsh[DATA_W-2:0], miso};
            end
        end
    end
endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic              cfg_trig_read,
    input  logic              cfg_send_zero,
    input  logic              cfg_get_more,
    input  logic [BAUD_W-1:0] cfg_baud,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_re,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              txf,
    output logic              rxf,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [SEL_W-1:0]  ss_n
);
    localparam int ECW = $clog2(2 * DATA_W) + 1;

    cfg_t              cfg_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] txbuf, lastw, rxbuf, word_sel, rx_word;
    logic              txf_q, rxf_q, busy_q, pend;
    logic              start, ev, cfg_ok;
    logic              sck_r, lead, trail, last;
    logic [ECW-1:0]    last_idx;

    assign start    = pend && !busy_q;
    assign ev       = (cfg_q.trig == TRIG_ON_READ) ? rx_re : tx_we;
    assign cfg_ok   = cfg_we && !busy_q && !pend;
    assign word_sel = txf_q ? txbuf : (cfg_q.send_zero ? '0 : lastw);
    assign last_idx = cfg_q.wide ? ECW'(2 * DATA_W - 1) : ECW'(DATA_W - 1);

    spim_clkgen #(.BAUD_W(BAUD_W), .ECW(ECW)) u_clk (
        .clk(clk), .rst(rst), .start(start), .run(busy_q), .cpol(cfg_q.cpol),
        .half(eff_half(cfg_q.baud)), .last_idx(last_idx),
        .sck_r(sck_r), .lead(lead), .trail(trail), .last(last)
    );

    spim_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk(clk), .rst(rst), .start(start), .load_word(word_sel),
        .cpha(cfg_q.cpha), .wide(cfg_q.wide), .lead(lead), .trail(trail),
        .miso(miso), .mosi(mosi), .rx_word(rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{cpol: 1'b0, cpha: 1'b0, wide: 1'b0, trig: TRIG_ON_WRITE,
                        send_zero: 1'b0, get_more: 1'b0, baud: BAUD_W'(2)};
            sel_q  <= '0;
            txbuf  <= '0;
            lastw  <= '0;
            rxbuf  <= '0;
            txf_q  <= 1'b0;
            rxf_q  <= 1'b0;
            busy_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (cfg_ok) begin
                cfg_q.cpol      <= cfg_cpol;
                cfg_q.cpha      <= cfg_cpha;
                cfg_q.wide      <= cfg_wide;
                cfg_q.trig      <= trig_e'(cfg_trig_read);
                cfg_q.send_zero <= cfg_send_zero;
                cfg_q.get_more  <= cfg_get_more;
                cfg_q.baud      <= cfg_baud;
                sel_q           <= cfg_sel;
            end
            pend <= (pend && !start) || ev;
            if (start)     busy_q <= 1'b1;
            else if (last) busy_q <= 1'b0;
            if (tx_we)      txf_q <= 1'b1;
            else if (start) txf_q <= 1'b0;
            if (tx_we) txbuf <= tx_wdata;
            if (start) lastw <= word_sel;
            if (last && (!rxf_q || cfg_q.get_more)) begin
                rxbuf <= rx_word;
                rxf_q <= 1'b1;
            end else if (rx_re) begin
                rxf_q <= 1'b0;
            end
        end
    end

    assign ss_n     = cfg_q.cpha ? ~sel_q : ~(sel_q & {SEL_W{busy_q}});
    assign sck      = busy_q ? sck_r : cfg_q.cpol;
    assign rx_rdata = rxbuf;
    assign txf      = txf_q;
    assign rxf      = rxf_q;
    assign busy     = busy_q;
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk
    import spim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input cfg_t              cfg,
    input logic              busy,
    input logic              txf,
    input logic              rxf,
    input logic              tx_we,
    input logic              rx_re,
    input logic [DATA_W-1:0] rx_rdata,
    input logic              sck,
    input logic [SEL_W-1:0]  ss_n
);
    AST_SS_AUTO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg.cpha) |-> (ss_n == {SEL_W{1'b1}})); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg)); // R10

    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        (rxf && !cfg.get_more && !rx_re) |=> $stable(rx_rdata)); // R6

    AST_TXF_SET: assert property (@(posedge clk) disable iff (rst)
        tx_we |=> txf); // R12

    AST_SCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $stable(cfg.cpol)) |-> $stable(sck)); // R11
endmodule

bind spim_master spim_master_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst(rst), .cfg(cfg_q), .busy(busy), .txf(txf), .rxf(rxf),
    .tx_we(tx_we), .rx_re(rx_re), .rx_rdata(rx_rdata), .sck(sck), .ss_n(ss_n)
);

// File: tb/spim_master_tb.sv
module spim_master_tb;
    localparam int DW = 16;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_wide = 0, cfg_trig_read = 0;
    logic cfg_send_zero = 0, cfg_get_more = 0;
    logic [15:0] cfg_baud = 16'd2;
    logic [SW-1:0] cfg_sel = '0;
    logic tx_we = 0, rx_re = 0;
    logic [DW-1:0] tx_wdata = '0;
    logic [DW-1:0] rx_rdata;
    logic txf, rxf, busy, sck, mosi, miso;
    logic [SW-1:0] ss_n;

    int errors = 0;
    int checks = 0;
    logic [15:0] mon = '0;
    logic b_cpol = 0, b_cpha = 0;

    always #4 clk = ~clk;
    assign miso = mosi;

    spim_master #(.DATA_W(DW), .SEL_W(SW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_wide(cfg_wide), .cfg_trig_read(cfg_trig_read), .cfg_send_zero(cfg_send_zero),
        .cfg_get_more(cfg_get_more), .cfg_baud(cfg_baud), .cfg_sel(cfg_sel),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_rdata(rx_rdata),
        .txf(txf), .rxf(rxf), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // wire monitor: sampling edge level is 1 when polarity equals phase
    always @(sck) if (sck === ~(b_cpol ^ b_cpha)) mon = {mon[14:0], mosi};

    // stimulus: cpol, cpha, wide, baud[15:0], word[15:0]
    localparam logic [34:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 16'd2, 16'h00A5},
        {1'b0, 1'b1, 1'b0, 16'd3, 16'h003C},
        {1'b1, 1'b0, 1'b1, 16'd0, 16'hBEEF},
        {1'b1, 1'b1, 1'b1, 16'd1, 16'h1234},
        {1'b0, 1'b0, 1'b1, 16'd4, 16'h8001},
        {1'b1, 1'b1, 1'b0, 16'd2, 16'h00C3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic pol, input logic pha, input logic wd, input logic trd,
                           input logic zr, input logic mr, input logic [15:0] bd,
                           input logic [SW-1:0] sl);
        @(negedge clk);
        cfg_we = 1; cfg_cpol = pol; cfg_cpha = pha; cfg_wide = wd; cfg_trig_read = trd;
        cfg_send_zero = zr; cfg_get_more = mr; cfg_baud = bd; cfg_sel = sl;
        @(negedge clk);
        cfg_we = 0;
        b_cpol = pol; b_cpha = pha;
    endtask

    task automatic pulse_tx(input logic [DW-1:0] d);
        @(negedge clk); tx_we = 1; tx_wdata = d;
        @(negedge clk); tx_we = 0;
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_re = 1;
        @(negedge clk); rx_re = 0;
    endtask

    task automatic wait_done(output int cnt, output logic [SW-1:0] ss_mid);
        cnt = 0; ss_mid = '1;
        for (int g = 0; g < 5000; g++) begin
            if (busy) begin
                if (cnt == 0) ss_mid = ss_n;
                cnt++;
            end else if (cnt > 0) begin
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cnt;
        logic [SW-1:0] ssm;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R13 reset state
        chk("R13 busy", busy, 0);
        chk("R13 txf", txf, 0);
        chk("R13 rxf", rxf, 0);
        chk("R13 rx_rdata", rx_rdata, 0);
        chk("R13 sck", sck, 0);
        chk("R13 ss_n", ss_n, 4'hF);

        // vector walk: R1 write trigger, R2 data, R9 timing, R11 idle level, R7, R12
        for (int i = 0; i < 6; i++) begin
            logic [34:0] v;
            logic [15:0] w, expw;
            int bits, eff;
            v = VEC[i];
            w = v[15:0];
            bits = v[32] ? 16 : 8;
            eff = (v[31:16] < 2) ? 2 : int'(v[31:16]);
            expw = v[32] ? w : {8'h00, w[7:0]};
            set_cfg(v[34], v[33], v[32], 1'b0, 1'b0, 1'b1, v[31:16], 4'b0001);
            pulse_rx();
            pulse_tx(w);
            wait_done(cnt, ssm);
            @(negedge clk);
            chk("R1 R2 rx word", rx_rdata, expw);
            chk("R2 msb-first wire", v[32] ? mon : {8'h00, mon[7:0]}, expw);
            chk("R9 busy cycles", cnt, 2 * bits * eff);
            chk("R11 sck idle", sck, v[34]);
            chk("R12 rxf", rxf, 1);
            chk("R12 txf", txf, 0);
            if (!v[33]) chk("R7 ss during word", ssm, 4'b1110);
            if (!v[33]) chk("R7 ss idle", ss_n, 4'hF);
        end

        // R6 drop then R5 overwrite
        set_cfg(0, 0, 0, 0, 0, 0, 16'd2, 4'b0001);
        pulse_rx();
        pulse_tx(16'h0011); wait_done(cnt, ssm);
        @(negedge clk);
        chk("R6 first store", rx_rdata, 16'h0011);
        pulse_tx(16'h0022); wait_done(cnt, ssm);
        @(negedge clk);
        chk("R6 full receive discards", rx_rdata, 16'h0011);
        chk("R6 rxf stays", rxf, 1);
        set_cfg(0, 0, 0, 0, 0, 1, 16'd2, 4'b0001);
        pulse_tx(16'h0033); wait_done(cnt, ssm);
        @(negedge clk);
        chk("R5 full receive overwrites", rx_rdata, 16'h0033);

        // R1 read trigger, R3 zeros, R4 repeat
        set_cfg(0, 0, 0, 1, 1, 1, 16'd2, 4'b0001);
        pulse_tx(16'h005A);
        repeat (10) @(negedge clk);
        chk("R1 write does not start in read mode", busy, 0);
        chk("R12 txf held", txf, 1);
        pulse_rx(); wait_done(cnt, ssm);
        @(negedge clk);
        chk("R1 read starts word", rx_rdata, 16'h005A);
        chk("R12 txf consumed", txf, 0);
        pulse_rx(); wait_done(cnt, ssm);
        @(negedge clk);
        chk("R3 empty sends zeros", rx_rdata, 16'h0000);
        pulse_tx(16'h0077);
        pulse_rx(); wait_done(cnt, ssm);
        @(negedge clk);
        chk("R4 load word", rx_rdata, 16'h0077);
        set_cfg(0, 0, 0, 1, 0, 1, 16'd2, 4'b0001);
        pulse_rx(); wait_done(cnt, ssm);
        @(negedge clk);
        chk("R4 empty repeats last", rx_rdata, 16'h0077);
        pulse_rx();
        @(negedge clk);
        chk("R12 rxf cleared by read", rxf, 0);
        wait_done(cnt, ssm);

        // R8 software-held selects
        set_cfg(0, 1, 0, 0, 0, 1, 16'd2, 4'b1010);
        @(negedge clk);
        chk("R8 ss idle", ss_n, 4'b0101);
        pulse_tx(16'h0066); wait_done(cnt, ssm);
        chk("R8 ss during word", ssm, 4'b0101);
        @(negedge clk);
        chk("R8 ss after word", ss_n, 4'b0101);

        // R10 configuration ignored while busy
        set_cfg(0, 0, 0, 0, 0, 1, 16'd2, 4'b0001);
        pulse_tx(16'h0099);
        @(negedge clk); cfg_we = 1; cfg_cpol = 1; cfg_baud = 16'd5; cfg_wide = 1;
        @(negedge clk); cfg_we = 0;
        wait_done(cnt, ssm);
        @(negedge clk);
        chk("R10 sck level kept", sck, 0);
        pulse_tx(16'h0042); wait_done(cnt, ssm);
        chk("R10 divider kept", cnt, 32);
        @(negedge clk);
        chk("R10 width kept", rx_rdata, 16'h0042);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule